// File: doc/BRIEF.md
# Serial Byte-Port Slave with Per-Frame Status Handshake

This block links an external serial master to two local byte queues: a transmit queue that the local side fills and the master drains, and a receive queue that the master fills and the local side drains. The master runs every transaction as a fixed frame of 13 rising edges on its serial clock. Each frame carries a start bit, a direction bit, an address bit, eight data bits MSB first, one status bit and one idle cycle. The serial clock, chip select and serial input are oversampled by the fast system clock, so the block lives entirely in one clock domain.

Every frame ends with a single status bit from the slave. On a read it tells the master whether the byte just shifted out is fresh or a repeat. On a write it tells the master whether the receive queue took the byte. Either way the master polls: it repeats a read until the status is 0, and it resends a write until the status is 0. A second address selects a status byte that reports queue occupancy. Dropping chip select before the status edge abandons the frame with no effect on either queue.

Top module: `sbp_slave`

## Requirements
- R1: After reset `sdo` is 0, `txFull` is 0 and `rxEmpty` is 1.
- R2: A frame starts only on a rising `sclk` edge where both `cs` and `sdi` are 1. With `cs` high and `sdi` low, or `cs` low, edges start nothing and `sdo` stays 0. A frame spans rising edges 1 to 13. Edge 2 samples the direction (1 = read, 0 = write) and edge 3 samples the address (0 = data queue, 1 = status byte).
- R3: On a read, the byte appears on `sdo` MSB first. Bit 7-(n-4) is launched after rising edge n, for n = 4..11.
- R4: A data read with a non-empty transmit queue returns the head byte. Status 0 is launched after edge 12, and that byte is popped.
- R5: A data read with an empty transmit queue returns the byte last delivered (0 after reset). Status 1 is launched, and nothing is popped.
- R6: On a write, `sdi` sampled at edges 4..11 forms the byte MSB first. If the receive queue is not full, status 0 is launched after edge 12 and the byte is pushed.
- R7: A data write while the receive queue is full launches status 1, and the byte is discarded.
- R8: If `cs` goes low before edge 12, the frame is abandoned. Nothing is pushed or popped, `sdo` returns to 0, and the next frame needs a new start bit.
- R9: `sdo` is 0 in cycles 1 to 3, in cycle 13, and between frames. It is also 0 during the data phase of a write.
- R10: A read of the status address returns the byte {6'b0, receive-full, transmit-empty} with status 0, and pops nothing. A write to the status address returns status 1 and pushes nothing.
- R11: Each queue holds 16 bytes in order. `txFull` rises after 16 pushes, and a local push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs | input | 1 | Chip select, active high |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data and status to the master |
| txPush | input | 1 | Local push into the transmit queue |
| txByte | input | 8 | Byte to push into the transmit queue |
| txFull | output | 1 | Transmit queue is full |
| rxPop | input | 1 | Local pop from the receive queue |
| rxByte | output | 8 | Head of the receive queue (show-ahead) |
| rxEmpty | output | 1 | Receive queue is empty |

## Verification
The assertions assume that `sclk` is slow next to `clk`, with each level held for at least three system clocks. They also assume that `cs` and `sdi` change only while `sclk` is low, so that the synchronised copies are settled when a rising edge is detected. Under those assumptions the idle-low, abort, reject and stale-status properties tie the serial frame to the queue state. The stimulus holds each `sclk` phase for four system clocks and changes `cs` and `sdi` only at the start of a low phase. It also samples `sdo` at the end of each serial cycle, well after the launch delay of three system clocks.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  // strobes from frame control to the datapath, valid for one system clock
  typedef struct packed {
    logic load;    // first data edge of a read: pick the byte to send
    logic shift;   // data edge: shift out (read) or shift in (write)
    logic commit;  // status edge: push/pop and launch status
    logic quiet;   // frame end or abort: park sdo low
    logic isRead;  // latched direction
    logic isStat;  // latched address
    logic bitIn;   // synchronised serial input
  } sbpStrobe_t;
endpackage

// File: rtl/sbp_fifo.sv
module sbp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == $past(count)));

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> $stable(count));
endmodule

// File: rtl/sbp_ctrl.sv
module sbp_ctrl #(
  parameter int DATA_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclk,
  input  logic                cs,
  input  logic                sdi,
  output sbp_pkg::sbpStrobe_t strb,
  output logic                frameOn
);
  localparam int DIR_EDGE   = 2;
  localparam int ADDR_EDGE  = 3;
  localparam int FIRST_DATA = ADDR_EDGE + 1;
  localparam int LAST_DATA  = FIRST_DATA + DATA_BITS - 1;
  localparam int STAT_EDGE  = LAST_DATA + 1;
  localparam int LAST_EDGE  = STAT_EDGE + 1;
  localparam int CW         = $clog2(LAST_EDGE + 1);

  logic          sclkS1, sclkS2, sclkPrev;
  logic          csS1, csS2, sdiS1, sdiS2;
  logic          rise;
  logic [CW-1:0] edgeCnt, nextEdge;
  logic          isRead, isStat;

  assign rise     = sclkS2 && !sclkPrev;
  assign nextEdge = edgeCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclkS1, sclkS2, sclkPrev} <= '0;
      {csS1, csS2, sdiS1, sdiS2} <= '0;
    end else begin
      sclkS1   <= sclk;
      sclkS2   <= sclkS1;
      sclkPrev <= sclkS2;
      csS1     <= cs;
      csS2     <= csS1;
      sdiS1    <= sdi;
      sdiS2    <= sdiS1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameOn <= 1'b0;
      edgeCnt <= '0;
      isRead  <= 1'b0;
      isStat  <= 1'b0;
    end else if (frameOn && !csS2) begin
      frameOn <= 1'b0;
      edgeCnt <= '0;
    end else if (rise) begin
      if (!frameOn) begin
        if (csS2 && sdiS2) begin
          frameOn <= 1'b1;
          edgeCnt <= CW'(1);
        end
      end else begin
        edgeCnt <= nextEdge;
        if (nextEdge == CW'(DIR_EDGE))  isRead <= sdiS2;
        if (nextEdge == CW'(ADDR_EDGE)) isStat <= sdiS2;
        if (nextEdge == CW'(LAST_EDGE)) begin
          frameOn <= 1'b0;
          edgeCnt <= '0;
        end
      end
    end
  end

  always_comb begin
    strb        = '0;
    strb.isRead = isRead;
    strb.isStat = isStat;
    strb.bitIn  = sdiS2;
    if (frameOn && !csS2) begin
      strb.quiet = 1'b1;
    end else if (frameOn && rise) begin
      if (nextEdge == CW'(FIRST_DATA)) begin
        strb.load  = isRead;
        strb.shift = !isRead;
      end else if (nextEdge > CW'(FIRST_DATA) && nextEdge <= CW'(LAST_DATA)) begin
        strb.shift = 1'b1;
      end
      strb.commit = (nextEdge == CW'(STAT_EDGE));
      strb.quiet  = (nextEdge == CW'(LAST_EDGE));
    end
  end

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameOn && !csS2) |=> !frameOn);

  // R2
  start_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameOn) |-> ($past(csS2) && $past(sdiS2)));
endmodule

// File: rtl/sbp_dpath.sv
module sbp_dpath #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  sbp_pkg::sbpStrobe_t strb,
  input  logic                txPush,
  input  logic [W-1:0]        txByte,
  input  logic                rxPop,
  output logic                txFull,
  output logic [W-1:0]        rxByte,
  output logic                rxEmpty,
  output logic                sdo
);
  logic [W-1:0] txHead, shReg, lastByte, statusByte, loadByte;
  logic         txEmpty, rxFull, staleFlag, txPop, rxPush;

  assign statusByte = {{(W-2){1'b0}}, rxFull, txEmpty};
  assign loadByte   = strb.isStat ? statusByte : (txEmpty ? lastByte : txHead);
  assign txPop      = strb.commit && strb.isRead && !strb.isStat && !staleFlag;
  assign rxPush     = strb.commit && !strb.isRead && !strb.isStat && !rxFull;

  sbp_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(txPush), .din(txByte), .pop(txPop),
    .head(txHead), .full(txFull), .empty(txEmpty));

  sbp_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(rxPush), .din(shReg), .pop(rxPop),
    .head(rxByte), .full(rxFull), .empty(rxEmpty));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdo       <= 1'b0;
      shReg     <= '0;
      lastByte  <= '0;
      staleFlag <= 1'b0;
    end else if (strb.quiet) begin
      sdo <= 1'b0;
    end else if (strb.load) begin
      sdo       <= loadByte[W-1];
      shReg     <= loadByte << 1;
      staleFlag <= !strb.isStat && txEmpty;
    end else if (strb.shift) begin
      if (strb.isRead) begin
        sdo   <= shReg[W-1];
        shReg <= shReg << 1;
      end else begin
        shReg <= {shReg[W-2:0], strb.bitIn};
      end
    end else if (strb.commit) begin
      if (strb.isRead) sdo <= staleFlag && !strb.isStat;
      else             sdo <= strb.isStat || rxFull;
      if (txPop) lastByte <= txHead;
    end
  end

  // R7
  reject_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !strb.isRead && rxFull) |=> sdo);

  // R5
  stale_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.isRead && !strb.isStat && staleFlag) |=> sdo);

  // R4
  fresh_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.isRead && !strb.isStat && !staleFlag) |-> !txEmpty);
endmodule

// File: rtl/sbp_slave.sv
module sbp_slave #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              cs,
  input  logic              sdi,
  output logic              sdo,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txByte,
  output logic              txFull,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxEmpty
);
  sbp_pkg::sbpStrobe_t strb;
  logic                frameOn;

  sbp_ctrl #(.DATA_BITS(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .cs(cs), .sdi(sdi),
    .strb(strb), .frameOn(frameOn));

  sbp_dpath #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .txPush(txPush), .txByte(txByte),
    .rxPop(rxPop), .txFull(txFull), .rxByte(rxByte), .rxEmpty(rxEmpty),
    .sdo(sdo));

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameOn |-> !sdo);
endmodule

// File: tb/sbp_slave_tb.sv
module sbp_slave_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic sclk = 1'b0, cs = 1'b0, sdi = 1'b0;
  logic txPush = 1'b0, rxPop = 1'b0;
  logic [7:0] txByte = '0;
  logic sdo, txFull, rxEmpty;
  logic [7:0] rxByte;
  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sbp_slave u_dut (.clk(clk), .rstN(rstN), .sclk(sclk), .cs(cs), .sdi(sdi),
    .sdo(sdo), .txPush(txPush), .txByte(txByte), .txFull(txFull),
    .rxPop(rxPop), .rxByte(rxByte), .rxEmpty(rxEmpty));

  // {read, statusAddr, dataIn, expectedByte, expectedStatus}
  localparam logic [18:0] VEC [8] = '{
    {1'b1, 1'b0, 8'h00, 8'hA5, 1'b0},  // R3 R4 fresh head
    {1'b0, 1'b0, 8'h5A, 8'h00, 1'b0},  // R6 write accepted
    {1'b1, 1'b0, 8'h00, 8'h3C, 1'b0},  // R4 second byte
    {1'b1, 1'b0, 8'h00, 8'h3C, 1'b1},  // R5 empty repeats last
    {1'b1, 1'b1, 8'h00, 8'h01, 1'b0},  // R10 status byte
    {1'b0, 1'b0, 8'hC3, 8'h00, 1'b0},  // R6 write accepted
    {1'b0, 1'b1, 8'h77, 8'h00, 1'b1},  // R10 write to status rejected
    {1'b1, 1'b1, 8'h00, 8'h01, 1'b0}   // R10 status byte again
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic bitFor(input int k, input logic rd, input logic st, input logic [7:0] d);
    if (k == 1) return 1'b1;
    if (k == 2) return rd;
    if (k == 3) return st;
    if (k >= 4 && k <= 11) return d[11 - k];
    return 1'b0;
  endfunction

  // abortAt: cycle whose rising edge is replaced by cs low (0 = none)
  task automatic runFrame(input logic rd, input logic st, input logic [7:0] din,
                          input int abortAt, output logic [7:0] got,
                          output logic stat, output logic quietOk);
    logic [13:0] seen;
    bit stopped;
    seen = '0;
    stopped = 0;
    for (int k = 1; k <= 13; k++) begin
      if (!stopped) begin
        @(negedge clk);
        sclk = 1'b0;
        sdi  = bitFor(k, rd, st, din);
        cs   = (k == abortAt) ? 1'b0 : 1'b1;
        repeat (4) @(negedge clk);
        if (k > 1) seen[k-1] = sdo;
        if (k == abortAt) stopped = 1;
        else begin
          sclk = 1'b1;
          repeat (4) @(negedge clk);
        end
      end
    end
    if (!stopped) begin
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      seen[13] = sdo;
    end
    cs = 1'b0;
    sdi = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) got[7-i] = seen[4+i];
    stat = seen[12];
    quietOk = (seen[3:1] == 3'b000) && !seen[13];
  endtask

  task automatic pushTx(input logic [7:0] b);
    @(negedge clk);
    txPush = 1'b1;
    txByte = b;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic popRx(input string tag, input logic [7:0] exp);
    @(negedge clk);
    check(tag, {31'b0, rxEmpty}, 32'd0);
    check(tag, {24'b0, rxByte}, {24'b0, exp});
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic stat, qOk;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 sdo", {31'b0, sdo}, 32'd0);
    check("R1 txFull", {31'b0, txFull}, 32'd0);
    check("R1 rxEmpty", {31'b0, rxEmpty}, 32'd1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // vector table
    pushTx(8'hA5);
    pushTx(8'h3C);
    for (int v = 0; v < 8; v++) begin
      runFrame(VEC[v][18], VEC[v][17], VEC[v][16:9], 0, got, stat, qOk);
      check($sformatf("R3/R6/R10 vec%0d byte", v), {24'b0, got}, {24'b0, VEC[v][8:1]});
      check($sformatf("R4/R5/R7 vec%0d status", v), {31'b0, stat}, {31'b0, VEC[v][0]});
      check($sformatf("R9 vec%0d quiet", v), {31'b0, qOk}, 32'd1);
    end
    popRx("R6 rx first", 8'h5A);
    popRx("R6 rx second", 8'hC3);
    @(negedge clk);
    check("R10 status write not pushed", {31'b0, rxEmpty}, 32'd1);

    // R2: cs high but sdi low starts nothing
    pushTx(8'h11);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sclk = 1'b0; cs = 1'b1; sdi = 1'b0;
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk);
      check("R2 no start sdo", {31'b0, sdo}, 32'd0);
    end
    // R2: sdi high but cs low starts nothing
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); sclk = 1'b0; cs = 1'b0; sdi = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk);
      check("R2 cs low sdo", {31'b0, sdo}, 32'd0);
    end
    @(negedge clk); sclk = 1'b0; sdi = 1'b0;
    repeat (4) @(negedge clk);

    // R8: abort a read in the data phase
    runFrame(1'b1, 1'b0, 8'h00, 8, got, stat, qOk);
    @(negedge clk);
    check("R8 sdo low after abort", {31'b0, sdo}, 32'd0);
    runFrame(1'b1, 1'b0, 8'h00, 0, got, stat, qOk);
    check("R8 byte not popped by abort", {24'b0, got}, 32'h11);
    check("R8 status fresh after abort", {31'b0, stat}, 32'd0);

    // R8: abort a write just before the status edge
    runFrame(1'b0, 1'b0, 8'hEE, 12, got, stat, qOk);
    @(negedge clk);
    check("R8 write abort not pushed", {31'b0, rxEmpty}, 32'd1);

    // R11/R7: fill the receive queue, then overflow
    for (int i = 0; i < 16; i++) begin
      runFrame(1'b0, 1'b0, 8'(i * 7 + 1), 0, got, stat, qOk);
      check("R6 fill accept", {31'b0, stat}, 32'd0);
    end
    runFrame(1'b1, 1'b1, 8'h00, 0, got, stat, qOk);
    check("R10 status rx full tx empty", {24'b0, got}, 32'h03);
    runFrame(1'b0, 1'b0, 8'hF0, 0, got, stat, qOk);
    check("R7 reject when full", {31'b0, stat}, 32'd1);
    for (int i = 0; i < 16; i++) popRx("R11 rx order", 8'(i * 7 + 1));
    @(negedge clk);
    check("R7 rejected byte discarded", {31'b0, rxEmpty}, 32'd1);

    // R11: fill the transmit queue, drop the extra push
    for (int i = 0; i < 17; i++) pushTx(8'(8'h80 + i));
    @(negedge clk);
    check("R11 txFull", {31'b0, txFull}, 32'd1);
    for (int i = 0; i < 16; i++) begin
      runFrame(1'b1, 1'b0, 8'h00, 0, got, stat, qOk);
      check("R11 tx order", {24'b0, got}, {24'b0, 8'(8'h80 + i)});
      check("R4 fresh status", {31'b0, stat}, 32'd0);
    end
    runFrame(1'b1, 1'b0, 8'h00, 0, got, stat, qOk);
    check("R5 stale repeat", {24'b0, got}, 32'h8F);
    check("R5 stale status", {31'b0, stat}, 32'd1);
    check("R11 txFull cleared", {31'b0, txFull}, 32'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule